// File: doc/BRIEF.md
# Configurable Sum-of-Products Output Array

This block is a small combinational array-logic core. A programmable AND plane forms product terms. Its inputs are the primary inputs and the values seen on the output pads, each available in true and complemented form. Each output cell owns a group of product terms. Those terms are ORed into a sum, and a per-cell style code chooses how the sum reaches the pin. Every cell has one more product term, and that term drives the cell's output enable.

All configuration arrives on one static flat fuse vector. Pads are split into three signals: a driven value, an enable, and the observed pad value. When a pin is disabled, the array can read it as an input. When it is enabled, the array reads back its own output. This allows a pin to be used as an output, an input or a bidirectional line. Cells are grouped in pairs. A pair can pool its product terms, and each cell in sharing style then takes the pooled terms that are assigned to it.

Top module: `pal_array`

## Requirements
- R1: A product term is the AND of every literal whose fuse is intact (fuse bit 1). For AND signal j, fuse 2j is the true literal and fuse 2j+1 is the complement. Signals 0..N_IN-1 are `in_i`, and signals N_IN.. are `pad_i`. A term with both literals of one signal intact is 0. Term t of cell k starts at fuse offset (k*(N_PT+1)+t)*2*(N_IN+N_OUT).
- R2: A product term with no intact fuse evaluates to 0.
- R3: Style code 0 (active-high) drives the OR of the cell's terms 0..N_PT-1 on `pin_o`. Style codes sit at offset N_OUT*(N_PT+1)*2*(N_IN+N_OUT) + 3k, three bits each.
- R4: Style code 1 (active-low) drives the inverted OR sum.
- R5: Style code 2 (complementary) drives the sum on `pin_o` and its inverse on `comp_o`. In every other style, `comp_o` is 0.
- R6: Style code 3 (programmable polarity) drives the sum XOR the cell's polarity bit. Polarity bits follow the style codes, one per cell.
- R7: Style code 4 (dual sum) drives the OR of terms 0..N_PT/2-1 XOR the OR of terms N_PT/2..N_PT-1.
- R8: Style code 5 (sharing) uses the pair's pooled terms. It drives the OR of the pool terms whose select bit names this cell (0 = even cell, 1 = odd cell). Pool index i < N_PT is the even cell's term i, and index N_PT+i is the odd cell's term i. The partner cell's style does not affect this. Select bits follow the polarity bits, 2*N_PT per pair.
- R9: `pin_oe_o[k]` equals product term N_PT of cell k.
- R10: Pad values feed the AND plane. The value driven externally on a disabled pin reaches dependent terms, and so does the cell's own output when the pin is enabled.
- R11: Reserved style codes 6 and 7 behave as active-high, with `comp_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_i | input | N_IN | Primary inputs to the AND plane |
| pad_i | input | N_OUT | Observed pad values, fed back into the AND plane |
| fuse_i | input | FUSE_W | Static flat configuration vector |
| pin_o | output | N_OUT | Value driven toward each pad |
| pin_oe_o | output | N_OUT | Per-pad output enable (product term) |
| comp_o | output | N_OUT | Inverse sum in complementary style, else 0 |

## Verification
The checks assume that the fuse vector is held constant while outputs are observed. They also assume that no product term reads, through `pad_i`, a pad driven by its own enabled cell, because such a loop could oscillate. The checks evaluate settled combinational values inside the block where each value is computed. The bench models the pad as the driven value when enabled and as an external value otherwise. It programs feedback only from pins whose cells do not depend on that pad, and it changes fuses and inputs only between sampling points.

// File: rtl/pal_pkg.sv
package pal_pkg;

    typedef enum logic [2:0] {
        ST_HIGH  = 3'd0,
        ST_LOW   = 3'd1,
        ST_COMP  = 3'd2,
        ST_POL   = 3'd3,
        ST_XOR   = 3'd4,
        ST_SHARE = 3'd5,
        ST_RSV6  = 3'd6,
        ST_RSV7  = 3'd7
    } style_e;

    typedef struct packed {
        logic pin;
        logic comp;
    } cell_out_t;

    localparam int STYLE_BITS = 3;

endpackage

// File: rtl/pal_product_term.sv
module pal_product_term #(
    parameter int N_SIG = 12,
    localparam int FPT = 2 * N_SIG
) (
    input  logic [FPT-1:0]   fuse_i,
    input  logic [N_SIG-1:0] sig_i,
    output logic             term_o
);

    logic any_conn;
    logic all_true;
    logic clash;

    always_comb begin
        any_conn = 1'b0;
        all_true = 1'b1;
        clash    = 1'b0;
        for (int j = 0; j < N_SIG; j++) begin
            if (fuse_i[2*j]) begin
                any_conn = 1'b1;
                if (!sig_i[j]) all_true = 1'b0;
            end
            if (fuse_i[2*j+1]) begin
                any_conn = 1'b1;
                if (sig_i[j]) all_true = 1'b0;
            end
            if (fuse_i[2*j] && fuse_i[2*j+1]) clash = 1'b1;
        end
        term_o = any_conn & all_true;

        if (fuse_i == '0) begin
            assert_blank_term_zero_R2: assert (term_o == 1'b0);
        end
        if (clash) begin
            assert_clash_term_zero_R1: assert (term_o == 1'b0);
        end
    end

endmodule

// File: rtl/pal_pair_sums.sv
module pal_pair_sums #(
    parameter int N_PT = 8,
    localparam int HALF = N_PT / 2,
    localparam int POOL = 2 * N_PT
) (
    input  logic [N_PT-1:0] terms_lo_i,
    input  logic [N_PT-1:0] terms_hi_i,
    input  logic [POOL-1:0] sel_i,
    input  logic            share_lo_i,
    input  logic            share_hi_i,
    output logic            sum_lo_o,
    output logic            sum_hi_o,
    output logic            half_a_lo_o,
    output logic            half_b_lo_o,
    output logic            half_a_hi_o,
    output logic            half_b_hi_o
);

    logic [POOL-1:0] pool;
    logic            own_lo;
    logic            own_hi;
    logic            shr_lo;
    logic            shr_hi;

    always_comb begin
        pool   = {terms_hi_i, terms_lo_i};
        own_lo = |terms_lo_i;
        own_hi = |terms_hi_i;
        shr_lo = |(pool & ~sel_i);
        shr_hi = |(pool & sel_i);

        sum_lo_o    = share_lo_i ? shr_lo : own_lo;
        sum_hi_o    = share_hi_i ? shr_hi : own_hi;
        half_a_lo_o = |terms_lo_i[HALF-1:0];
        half_b_lo_o = |terms_lo_i[N_PT-1:HALF];
        half_a_hi_o = |terms_hi_i[HALF-1:0];
        half_b_hi_o = |terms_hi_i[N_PT-1:HALF];

        if (share_lo_i && share_hi_i) begin
            assert_pool_covered_R8: assert ((sum_lo_o | sum_hi_o) == (|pool));
        end
        if (share_lo_i && (sel_i == '1)) begin
            assert_lo_gave_all_R8: assert (sum_lo_o == 1'b0);
        end
        if (share_hi_i && (sel_i == '0)) begin
            assert_hi_gave_all_R8: assert (sum_hi_o == 1'b0);
        end
    end

endmodule

// File: rtl/pal_out_cell.sv
module pal_out_cell
    import pal_pkg::*;
(
    input  logic [STYLE_BITS-1:0] style_i,
    input  logic                  pol_i,
    input  logic                  sum_i,
    input  logic                  half_a_i,
    input  logic                  half_b_i,
    input  logic                  en_i,
    output logic                  pin_o,
    output logic                  oe_o,
    output logic                  comp_o
);

    style_e    st;
    cell_out_t res;

    always_comb begin
        st       = style_e'(style_i);
        res.pin  = sum_i;
        res.comp = 1'b0;
        case (st)
            ST_LOW:  res.pin = ~sum_i;
            ST_COMP: begin
                res.pin  = sum_i;
                res.comp = ~sum_i;
            end
            ST_POL:  res.pin = sum_i ^ pol_i;
            ST_XOR:  res.pin = half_a_i ^ half_b_i;
            default: res.pin = sum_i;
        endcase
        pin_o  = res.pin;
        comp_o = res.comp;
        oe_o   = en_i;

        if (st == ST_COMP) begin
            assert_comp_inverse_R5: assert (comp_o != pin_o);
        end else begin
            assert_comp_idle_R5: assert (comp_o == 1'b0);
        end
        if (st == ST_LOW) begin
            assert_low_inverts_R4: assert (pin_o != sum_i);
        end
        if (st == ST_XOR && half_a_i == half_b_i) begin
            assert_xor_equal_zero_R7: assert (pin_o == 1'b0);
        end
        if (st == ST_POL && pol_i) begin
            assert_pol_flips_R6: assert (pin_o != sum_i);
        end
    end

endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
#(
    parameter int N_IN  = 8,
    parameter int N_OUT = 4,
    parameter int N_PT  = 8,
    localparam int N_SIG    = N_IN + N_OUT,
    localparam int FPT      = 2 * N_SIG,
    localparam int TPO      = N_PT + 1,
    localparam int STY_BASE = N_OUT * TPO * FPT,
    localparam int POL_BASE = STY_BASE + STYLE_BITS * N_OUT,
    localparam int SEL_BASE = POL_BASE + N_OUT,
    localparam int N_PAIR   = N_OUT / 2,
    localparam int FUSE_W   = SEL_BASE + N_PAIR * 2 * N_PT
) (
    input  logic [N_IN-1:0]   in_i,
    input  logic [N_OUT-1:0]  pad_i,
    input  logic [FUSE_W-1:0] fuse_i,
    output logic [N_OUT-1:0]  pin_o,
    output logic [N_OUT-1:0]  pin_oe_o,
    output logic [N_OUT-1:0]  comp_o
);

    logic [N_SIG-1:0]                  sig;
    logic [N_OUT-1:0][N_PT:0]          terms;
    logic [N_OUT-1:0][STYLE_BITS-1:0]  sty;
    logic [N_OUT-1:0]                  sum;
    logic [N_OUT-1:0]                  half_a;
    logic [N_OUT-1:0]                  half_b;

    assign sig = {pad_i, in_i};

    for (genvar k = 0; k < N_OUT; k++) begin : g_cell
        for (genvar t = 0; t <= N_PT; t++) begin : g_term
            localparam int OFS = (k * TPO + t) * FPT;
            pal_product_term #(.N_SIG(N_SIG)) u_term (
                .fuse_i (fuse_i[OFS +: FPT]),
                .sig_i  (sig),
                .term_o (terms[k][t])
            );
        end

        assign sty[k] = fuse_i[STY_BASE + STYLE_BITS*k +: STYLE_BITS];

        pal_out_cell u_cell (
            .style_i  (sty[k]),
            .pol_i    (fuse_i[POL_BASE + k]),
            .sum_i    (sum[k]),
            .half_a_i (half_a[k]),
            .half_b_i (half_b[k]),
            .en_i     (terms[k][N_PT]),
            .pin_o    (pin_o[k]),
            .oe_o     (pin_oe_o[k]),
            .comp_o   (comp_o[k])
        );
    end

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        pal_pair_sums #(.N_PT(N_PT)) u_pair (
            .terms_lo_i  (terms[2*p][N_PT-1:0]),
            .terms_hi_i  (terms[2*p+1][N_PT-1:0]),
            .sel_i       (fuse_i[SEL_BASE + p*2*N_PT +: 2*N_PT]),
            .share_lo_i  (sty[2*p]   == ST_SHARE),
            .share_hi_i  (sty[2*p+1] == ST_SHARE),
            .sum_lo_o    (sum[2*p]),
            .sum_hi_o    (sum[2*p+1]),
            .half_a_lo_o (half_a[2*p]),
            .half_b_lo_o (half_b[2*p]),
            .half_a_hi_o (half_a[2*p+1]),
            .half_b_hi_o (half_b[2*p+1])
        );
    end

endmodule

// File: tb/sim_pal_array.sv
`timescale 1ns/1ps
module sim_pal_array;

    localparam int NI    = 8;
    localparam int NO    = 4;
    localparam int NP    = 8;
    localparam int NS    = NI + NO;
    localparam int FP    = 2 * NS;
    localparam int TP    = NP + 1;
    localparam int SB    = NO * TP * FP;
    localparam int PB    = SB + 3 * NO;
    localparam int LB    = PB + NO;
    localparam int FW    = LB + (NO / 2) * 2 * NP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [NI-1:0] in_v;
    logic [NO-1:0] ext;
    logic [NO-1:0] pad_w;
    logic [FW-1:0] fz;
    logic [NO-1:0] pin, oe, comp;

    assign pad_w = (oe & pin) | (~oe & ext);

    pal_array u0 (
        .in_i     (in_v),
        .pad_i    (pad_w),
        .fuse_i   (fz),
        .pin_o    (pin),
        .pin_oe_o (oe),
        .comp_o   (comp)
    );

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    // {in[7:0], pin[3:0], comp[3:0], oe[3:0]}
    localparam logic [19:0] VEC [9] = '{
        20'h8008F, 20'h8158F, 20'h86D0F, 20'h8828F, 20'h9718F,
        20'hFF38F, 20'h8318F, 20'h8CA0F, 20'h00080
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic lit(input int k, input int t, input int s, input bit neg);
        fz[(k*TP + t)*FP + 2*s + (neg ? 1 : 0)] = 1'b1;
    endtask

    task automatic sty(input int k, input logic [2:0] c);
        fz[SB + 3*k +: 3] = c;
    endtask

    task automatic apply(input logic [7:0] iv, input logic [3:0] ev);
        @(posedge clk);
        in_v = iv;
        ext  = ev;
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        in_v = '0;
        ext  = '0;
        fz   = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // blank configuration: all terms 0, high style (R2, R3, R9)
        apply(8'hFF, 4'h0);
        chk("R2 blank pin", pin, 4'h0);
        chk("R9 blank oe", oe, 4'h0);
        chk("R5 blank comp", comp, 4'h0);

        // configuration for the vector table
        fz = '0;
        lit(0, 0, 0, 0); lit(0, 1, 1, 0); lit(0, 1, 2, 0); sty(0, 3'd0);
        lit(1, 0, 3, 1); sty(1, 3'd1);
        lit(2, 0, 0, 0); lit(2, 4, 1, 0); sty(2, 3'd4);
        lit(3, 0, 2, 0); lit(3, 0, 4, 1); sty(3, 3'd2);
        for (int k = 0; k < NO; k++) lit(k, NP, 7, 0);
        for (int v = 0; v < 9; v++) begin
            apply(VEC[v][19:12], 4'h0);
            chk($sformatf("R3 R4 R7 R1 vec%0d pin", v), pin, VEC[v][11:8]);
            chk($sformatf("R5 vec%0d comp", v), comp, VEC[v][7:4]);
            chk($sformatf("R9 vec%0d oe", v), oe, VEC[v][3:0]);
        end

        // R2: blank terms under active-low give a constant 1
        fz = '0;
        sty(1, 3'd1);
        apply(8'hA5, 4'h0);
        chk("R2 low blank", {3'b0, pin[1]}, 4'h1);

        // R1: both literals of one signal intact -> term 0
        lit(1, 0, 0, 0); lit(1, 0, 0, 1);
        apply(8'h01, 4'h0);
        chk("R1 clash in=1", {3'b0, pin[1]}, 4'h1);
        apply(8'h00, 4'h0);
        chk("R1 clash in=0", {3'b0, pin[1]}, 4'h1);

        // R6: programmable polarity
        fz = '0;
        lit(1, 0, 0, 0); sty(1, 3'd3);
        fz[PB + 1] = 1'b1;
        apply(8'h01, 4'h0);
        chk("R6 pol1 in=1", {3'b0, pin[1]}, 4'h0);
        apply(8'h00, 4'h0);
        chk("R6 pol1 in=0", {3'b0, pin[1]}, 4'h1);
        fz[PB + 1] = 1'b0;
        apply(8'h01, 4'h0);
        chk("R6 pol0 in=1", {3'b0, pin[1]}, 4'h1);

        // R8: term sharing in pair 0
        fz = '0;
        lit(0, 0, 0, 0); lit(1, 0, 1, 0);
        sty(0, 3'd5); sty(1, 3'd5);
        fz[LB + 0]  = 1'b1;
        fz[LB + NP] = 1'b1;
        apply(8'h01, 4'h0);
        chk("R8 both to odd", pin & 4'h3, 4'h2);
        fz[LB + 0] = 1'b0;
        apply(8'h01, 4'h0);
        chk("R8 term0 to even", pin & 4'h3, 4'h1);
        sty(1, 3'd0);
        apply(8'h01, 4'h0);
        chk("R8 partner own terms", pin & 4'h3, 4'h1);
        fz[LB + NP] = 1'b0;
        apply(8'h02, 4'h0);
        chk("R8 even claims odd term", pin & 4'h3, 4'h3);

        // R11: reserved code acts as high
        fz = '0;
        lit(0, 0, 0, 0); sty(0, 3'd6);
        apply(8'h01, 4'h0);
        chk("R11 rsv6 pin", {3'b0, pin[0]}, 4'h1);
        chk("R11 rsv6 comp", comp, 4'h0);
        sty(0, 3'd7);
        apply(8'h00, 4'h0);
        chk("R11 rsv7 pin", {3'b0, pin[0]}, 4'h0);

        // R10: feedback from a disabled pin's external value
        fz = '0;
        lit(1, 0, NI + 0, 0); lit(1, NP, 7, 0);
        apply(8'h80, 4'h1);
        chk("R10 ext 1", {3'b0, pin[1]}, 4'h1);
        chk("R9 pin0 disabled", {3'b0, oe[0]}, 4'h0);
        apply(8'h80, 4'h0);
        chk("R10 ext 0", {3'b0, pin[1]}, 4'h0);
        // R10: enabled pin feeds back its own driven value
        lit(0, 0, 0, 0); lit(0, NP, 7, 0);
        apply(8'h81, 4'h0);
        chk("R10 enabled fb", {3'b0, pin[1]}, 4'h1);
        apply(8'h80, 4'h1);
        chk("R10 enabled ignores ext", {3'b0, pin[1]}, 4'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule